// File: doc/BRIEF.md
# Sensorless Six-Step Commutation Sequencer

This block drives the three half-bridges of a brushless motor that has no position sensors. For each of the three phases it holds one of three states: the upper switch on, the lower switch on, or both off so that the phase floats. Six such patterns make up one electrical revolution. In each pattern one phase is pulled high, one is pulled low and the third floats. An external comparator senses the back-EMF on the floating phase against the motor neutral and reports each zero crossing as a one-cycle flag for that phase.

At spin-up there is no back-EMF to sense, so the sequencer steps the pattern on a timer. The timer counts ticks of a slow startup oscillator. Whenever a zero-cross flag arrives, the sequencer jumps to the pattern that follows from that detection and restarts its timer. After a run of back-to-back steps taken on zero crossings, it reports that it is in driving mode. A single timer-forced step returns it to startup mode. Gate enables are registered, and every pattern change inserts one clock with all six gates off.

A direction input selects whether the pattern index counts up or down. A rotation output toggles on every step. Dropping the enable input parks the block: all gates go off and everything returns to its initial state.

Top module: `sensorless_commutator`

## Requirements
- R1: The pattern table uses the encoding bit0 = U, bit1 = V, bit2 = W on `gateHi`, `gateLo` and for the floating phase. Steps 0 to 5 are, as (high, low, floating): 0 (U,V,W), 1 (U,W,V), 2 (V,W,U), 3 (V,U,W), 4 (W,U,V), 5 (W,V,U). Outside a dead cycle and with enable high, the gates show the pattern of `stepIdx`, and `stepIdx` stays in 0..5.
- R2: No phase ever has its high and low enables asserted together.
- R3: On every step change, the clock after the change shows all six gates off. The clock after that shows the new pattern.
- R4: If no zero-cross is accepted, the step advances by one on the clock that samples the OSC_DIV-th oscillator tick (default 134) counted since the last step or since enable rose. One tick fewer leaves the step unchanged.
- R5: With `dirFwd` = 1 the step index moves upward modulo 6, so the high side runs U, V, W. With `dirFwd` = 0 it moves downward, so the order is U, W, V.
- R6: A zero-cross flag on phase P moves the step by 1, 2 or 3 positions in the current direction. The count is 1 if P floats in the current pattern, 2 if P floats in the next pattern, and 3 if P floats in the pattern after that. When several flags arrive together, the smallest move wins. An accepted zero-cross takes precedence over a timer step in the same cycle and restarts the timer.
- R7: `driveMode` is 0 after reset and after enable rises. It becomes 1 once SYNC_STEPS (default 2) consecutive steps have come from zero crossings. A timer-forced step returns it to 0.
- R8: `rotPulse` toggles exactly once for every step change made while enabled.
- R9: While `enable` is low, the next clock shows all gates off, `stepIdx` = 0, `driveMode` = 0 and `rotPulse` = 0, and the timer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Drive enable; low parks the sequencer |
| dirFwd | input | 1 | Rotation direction: 1 counts steps up, 0 counts down |
| oscTick | input | 1 | One-cycle tick from the startup oscillator |
| zeroCross | input | 3 | Per-phase zero-cross flags, bit0 = U, bit1 = V, bit2 = W |
| gateHi | output | 3 | High-side enables per phase |
| gateLo | output | 3 | Low-side enables per phase |
| stepIdx | output | 3 | Current pattern index 0..5 |
| driveMode | output | 1 | 0 = startup (timed), 1 = driving (zero-cross locked) |
| rotPulse | output | 1 | Toggles once per commutation step |

## Verification
The properties assume that zero-cross flags and oscillator ticks are one-cycle events sampled synchronously. They assume nothing about how often these arrive, so two steps may follow each other in back-to-back clocks. The stimulus redraws every flag and tick on each clock from a seeded generator. That keeps every event one cycle long, and it sometimes raises several zero-cross flags at once to exercise the priority rule. Enable and direction change only rarely, so that long timer runs and zero-cross lock-in both take place between changes.

// File: rtl/commseq_pkg.sv
package commseq_pkg;

  typedef struct packed {
    logic       clr;   // park everything
    logic       adv;   // take a step this cycle
    logic       fwd;   // step direction
    logic [1:0] amt;   // step distance 1..3
  } seqStrobe_t;

  // Move a step index by k positions (0..3) modulo 6
  function automatic logic [2:0] stepMove(input logic [2:0] s, input logic [1:0] k,
                                          input logic fwd);
    logic [3:0] t;
    if (fwd) t = {1'b0, s} + {2'b00, k};
    else     t = {1'b0, s} + 4'd6 - {2'b00, k};
    if (t >= 4'd6) t = t - 4'd6;
    return t[2:0];
  endfunction

  // Index of the floating phase for a step (0=U,1=V,2=W)
  function automatic logic [1:0] floatOf(input logic [2:0] s);
    case (s)
      3'd0, 3'd3: return 2'd2;
      3'd1, 3'd4: return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] hiOf(input logic [2:0] s);
    case (s)
      3'd0, 3'd1: return 3'b001;
      3'd2, 3'd3: return 3'b010;
      3'd4, 3'd5: return 3'b100;
      default:    return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] loOf(input logic [2:0] s);
    case (s)
      3'd0, 3'd5: return 3'b010;
      3'd1, 3'd2: return 3'b100;
      3'd3, 3'd4: return 3'b001;
      default:    return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/commutator_ctrl.sv
module commutator_ctrl
  import commseq_pkg::*;
#(
  parameter int OSC_DIV    = 134,
  parameter int SYNC_STEPS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       dirFwd,
  input  logic       oscTick,
  input  logic [2:0] zeroCross,
  input  logic [2:0] stepIdx,
  output seqStrobe_t strobe,
  output logic       driveMode
);
  localparam int CNT_W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam int RUN_W = $clog2(SYNC_STEPS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSC_DIV - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(SYNC_STEPS);
  localparam logic [RUN_W-1:0] RUN_LOCK = RUN_W'(SYNC_STEPS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [RUN_W-1:0] zcRun;
  logic [2:0]       probeHit;
  logic [1:0]       zcAmt;
  logic             timerDone;

  // Look at the floating phase of the current and the next two patterns
  for (genvar k = 0; k < 3; k++) begin : g_probe
    assign probeHit[k] = zeroCross[floatOf(stepMove(stepIdx, 2'(k), dirFwd))];
  end

  always_comb begin
    if (probeHit[0])      zcAmt = 2'd1;
    else if (probeHit[1]) zcAmt = 2'd2;
    else if (probeHit[2]) zcAmt = 2'd3;
    else                  zcAmt = 2'd0;
  end

  assign timerDone  = oscTick && (tickCnt == CNT_LAST);

  assign strobe.clr = !enable;
  assign strobe.adv = enable && ((zcAmt != 2'd0) || timerDone);
  assign strobe.fwd = dirFwd;
  assign strobe.amt = (zcAmt != 2'd0) ? zcAmt : 2'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt   <= '0;
      zcRun     <= '0;
      driveMode <= 1'b0;
    end else if (!enable) begin
      tickCnt   <= '0;
      zcRun     <= '0;
      driveMode <= 1'b0;
    end else if (zcAmt != 2'd0) begin
      tickCnt <= '0;
      if (zcRun >= RUN_LOCK) driveMode <= 1'b1;
      if (zcRun < RUN_MAX)   zcRun <= zcRun + 1'b1;
    end else if (oscTick) begin
      if (timerDone) begin
        tickCnt   <= '0;
        zcRun     <= '0;
        driveMode <= 1'b0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/commutator_path.sv
module commutator_path
  import commseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic [2:0] stepIdx,
  output logic [2:0] gateHi,
  output logic [2:0] gateLo,
  output logic       rotPulse
);
  logic [2:0] nextStep;

  assign nextStep = stepMove(stepIdx, strobe.amt, strobe.fwd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx  <= '0;
      gateHi   <= '0;
      gateLo   <= '0;
      rotPulse <= 1'b0;
    end else if (strobe.clr) begin
      stepIdx  <= '0;
      gateHi   <= '0;
      gateLo   <= '0;
      rotPulse <= 1'b0;
    end else if (strobe.adv) begin
      // dead cycle: all switches open while the pattern changes
      stepIdx  <= nextStep;
      gateHi   <= '0;
      gateLo   <= '0;
      rotPulse <= ~rotPulse;
    end else begin
      gateHi <= hiOf(stepIdx);
      gateLo <= loOf(stepIdx);
    end
  end

endmodule

// File: rtl/sensorless_commutator.sv
module sensorless_commutator
  import commseq_pkg::*;
#(
  parameter int OSC_DIV    = 134,
  parameter int SYNC_STEPS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       dirFwd,
  input  logic       oscTick,
  input  logic [2:0] zeroCross,
  output logic [2:0] gateHi,
  output logic [2:0] gateLo,
  output logic [2:0] stepIdx,
  output logic       driveMode,
  output logic       rotPulse
);
  seqStrobe_t strobe;

  commutator_ctrl #(
    .OSC_DIV   (OSC_DIV),
    .SYNC_STEPS(SYNC_STEPS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .dirFwd   (dirFwd),
    .oscTick  (oscTick),
    .zeroCross(zeroCross),
    .stepIdx  (stepIdx),
    .strobe   (strobe),
    .driveMode(driveMode)
  );

  commutator_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .gateHi  (gateHi),
    .gateLo  (gateLo),
    .rotPulse(rotPulse)
  );

endmodule

// File: rtl/commutator_checks.sv
module commutator_checks (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [2:0] gateHi,
  input logic [2:0] gateLo,
  input logic [2:0] stepIdx,
  input logic       driveMode,
  input logic       rotPulse
);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi & gateLo) == 3'b000); // R2

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx < 3'd6); // R1

  AST_ONE_HIGH_ONE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi != 3'b000) |-> ($countones(gateHi) == 1 && $countones(gateLo) == 1)); // R1

  AST_DEAD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx != $past(stepIdx)) |-> (gateHi == 3'b000 && gateLo == 3'b000)); // R3

  AST_ROT_PER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) |-> ((rotPulse != $past(rotPulse)) == (stepIdx != $past(stepIdx)))); // R8

  AST_PARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $past(!enable) |-> (gateHi == 3'b000 && gateLo == 3'b000 && stepIdx == 3'd0
                        && !driveMode && !rotPulse)); // R9

endmodule

bind sensorless_commutator commutator_checks u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .gateHi   (gateHi),
  .gateLo   (gateLo),
  .stepIdx  (stepIdx),
  .driveMode(driveMode),
  .rotPulse (rotPulse)
);

// File: tb/sensorless_commutator_bench.sv
`timescale 1ns/1ps
module sensorless_commutator_bench;
  localparam int DIV  = 134;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic       dir = 1'b1;
  logic       tick = 1'b0;
  logic [2:0] zc = 3'b000;
  logic [2:0] gateHi, gateLo, stepIdx;
  logic       driveMode, rotPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sensorless_commutator #(.OSC_DIV(DIV), .SYNC_STEPS(SYNC)) u_sensorless_commutator (
    .clk(clk), .rstN(rstN), .enable(en), .dirFwd(dir), .oscTick(tick), .zeroCross(zc),
    .gateHi(gateHi), .gateLo(gateLo), .stepIdx(stepIdx), .driveMode(driveMode),
    .rotPulse(rotPulse)
  );

  // ---------- expected values from the requirements ----------
  function automatic int bFloat(int s);
    case (s)
      0, 3:    return 2;
      1, 4:    return 1;
      default: return 0;
    endcase
  endfunction
  function automatic logic [2:0] bHi(int s);
    case (s)
      0, 1:    return 3'b001;
      2, 3:    return 3'b010;
      default: return 3'b100;
    endcase
  endfunction
  function automatic logic [2:0] bLo(int s);
    case (s)
      0, 5:    return 3'b010;
      1, 2:    return 3'b100;
      default: return 3'b001;
    endcase
  endfunction
  function automatic int bMove(int s, int k, bit fwd);
    return fwd ? (s + k) % 6 : (s + 6 - k) % 6;
  endfunction

  int         mStep, mCnt, mRun;
  logic [2:0] mHi, mLo;
  logic       mMode, mRot;

  always @(posedge clk or negedge rstN) begin : refModel
    int amt;
    bit timer;
    if (!rstN || !en) begin
      mStep <= 0; mCnt <= 0; mRun <= 0; mHi <= 0; mLo <= 0; mMode <= 0; mRot <= 0;
    end else begin
      amt = 0;
      for (int k = 0; k < 3; k++)
        if (amt == 0 && zc[bFloat(bMove(mStep, k, dir))]) amt = k + 1;
      timer = tick && (mCnt == DIV - 1);
      if (amt != 0 || timer) begin
        mStep <= bMove(mStep, (amt != 0) ? amt : 1, dir);
        mHi <= 3'b000; mLo <= 3'b000; mRot <= ~mRot;
      end else begin
        mHi <= bHi(mStep); mLo <= bLo(mStep);
      end
      if (amt != 0) begin
        mCnt <= 0;
        if (mRun >= SYNC - 1) mMode <= 1'b1;
        if (mRun < SYNC) mRun <= mRun + 1;
      end else if (tick) begin
        if (timer) begin mCnt <= 0; mRun <= 0; mMode <= 1'b0; end
        else mCnt <= mCnt + 1;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R1 gateHi", {5'b0, gateHi}, {5'b0, mHi});
      chk("R1 gateLo", {5'b0, gateLo}, {5'b0, mLo});
      chk("R2 overlap", {5'b0, gateHi & gateLo}, 8'h0);
      chk("R5 stepIdx", {5'b0, stepIdx}, 8'(mStep));
      chk("R7 driveMode", {7'b0, driveMode}, {7'b0, mMode});
      chk("R8 rotPulse", {7'b0, rotPulse}, {7'b0, mRot});
    end
  end

  task automatic tickFor(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R9 reset gates", {2'b0, gateHi, gateLo}, 8'h0);
    chk("R9 reset step", {5'b0, stepIdx}, 8'h0);
    rstN = 1'b1; en = 1'b1; dir = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 step0 pattern", {2'b0, gateHi, gateLo}, {2'b0, 3'b001, 3'b010});

    tickFor(DIV - 1);
    chk("R4 one tick short", {5'b0, stepIdx}, 8'd0);
    tickFor(1);
    chk("R4 timer step", {5'b0, stepIdx}, 8'd1);
    chk("R3 dead cycle", {2'b0, gateHi, gateLo}, 8'h0);
    @(negedge clk);
    chk("R3 new pattern", {2'b0, gateHi, gateLo}, {2'b0, 3'b001, 3'b100});

    zc = 3'b010; @(negedge clk); zc = 3'b000;
    chk("R6 floating phase hit", {5'b0, stepIdx}, 8'd2);
    chk("R7 one sync step", {7'b0, driveMode}, 8'd0);
    @(negedge clk);
    zc = 3'b100; @(negedge clk); zc = 3'b000;
    chk("R6 next-pattern hit", {5'b0, stepIdx}, 8'd4);
    chk("R7 locked", {7'b0, driveMode}, 8'd1);

    tickFor(DIV);
    chk("R7 fallback", {7'b0, driveMode}, 8'd0);
    chk("R4 fallback step", {5'b0, stepIdx}, 8'd5);

    en = 1'b0; @(negedge clk);
    chk("R9 parked", {1'b0, driveMode, gateHi, gateLo}, 8'h0);
    chk("R9 parked step", {6'b0, stepIdx[1:0] | {1'b0, stepIdx[2]}, rotPulse}, 8'h0);
    dir = 1'b0; en = 1'b1; @(negedge clk);
    tickFor(DIV);
    chk("R5 reverse step", {5'b0, stepIdx}, 8'd5);
    chk("R8 toggled", {7'b0, rotPulse}, 8'd1);
    @(negedge clk);
    zc = 3'b111; @(negedge clk); zc = 3'b000;
    chk("R6 priority", {5'b0, stepIdx}, 8'd4);

    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      tick = ($urandom % 2) == 0;
      if (($urandom % 30) == 0) zc = 3'($urandom % 8);
      else zc = 3'b000;
      if (($urandom % 600) == 0) en = ~en;
      if (($urandom % 350) == 0) dir = ~dir;
      if (!en && ($urandom % 8) == 0) en = 1'b1;
    end
    @(negedge clk);
    finishRun();
  end

endmodule